// File: doc/BRIEF.md
# Dual-Clock Serial Delay Memory

This block is a serial field store that works as a digital delay line with a programmable delay. Words go in on the write clock and come out on the read clock. The two clocks are independent and may run at different rates. The store has no address bus and no full or empty flags. Each side has its own address counter. A restart strobe on that side's clock returns the counter to location zero. The delay between input and output is therefore set only by when the write restart and the read restart arrive.

Each side has two qualifiers:

- **Write side.** The write enable freezes the address counter and blocks the write. The input enable only blocks the write, and the address still steps. Clearing the input enable lets a stream pass over a region of the store and leave it untouched, for example to overlay one picture on another.
- **Read side.** The read enable freezes the read address and holds the output. The output enable lets the address step but replaces the output word with a blank value, so those words are skipped.

The output is a register loaded from the storage array on the read clock. A read restart delivers word zero on that same edge, so there is no extra start-up latency. An asynchronous power-on reset clears the two counters and the output register. No other housekeeping input exists.

Top module: `serialDelayMem`

## Requirements
- R1: While `rstN` is low, `rdData` equals `BLANK` (default 0) and both address counters are at location 0.
- R2: A write-clock edge with `wrRestart` high uses location 0. Each later edge with `wrEn` and `inEn` high writes the next location in order.
- R3: A read-clock edge with `rdRestart` and `rdEn` high places word 0 on `rdData` right after that same edge, with no added cycle. Each later enabled edge presents the next location.
- R4: A write-clock edge with `wrEn` low writes nothing and leaves the write address unchanged.
- R5: A write-clock edge with `wrEn` high and `inEn` low advances the write address but leaves the addressed location with its old contents.
- R6: A read-clock edge with `rdEn` low leaves the read address unchanged and holds `rdData`.
- R7: A read-clock edge with `rdEn` high and `outEn` low advances the read address and drives `rdData` to `BLANK`.
- R8: Both address counters wrap from location `DEPTH-1` to location 0.
- R9: A restart takes priority over the enable. A restart edge with the enable low returns that counter to 0 with no access, so the next enabled edge uses location 0.
- R10: Stored words are kept with no further clock activity on either side, for any length of idle time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Asynchronous active-low power-on reset |
| wrClk | input | 1 | Write-side clock |
| wrRestart | input | 1 | Return the write address to location 0 |
| wrEn | input | 1 | Write enable; low freezes the write address |
| inEn | input | 1 | Input enable; low masks the write while the address steps |
| wrData | input | WIDTH | Word to store |
| rdClk | input | 1 | Read-side clock |
| rdRestart | input | 1 | Return the read address to location 0 |
| rdEn | input | 1 | Read enable; low freezes the read address and the output |
| outEn | input | 1 | Output enable; low blanks the output while the address steps |
| rdData | output | WIDTH | Registered output word |

## Verification
On every clock edge of its own side, the assertions check the following:

- **Counter stepping:** each counter steps by exactly one, wraps at the last location, holds when its enable is low, and lands on 0 or 1 after a restart.
- **Output control:** a read edge with `rdEn` low leaves `rdData` unchanged, and a blanked read produces `BLANK`.
- **Write gating:** no write strobe is ever raised while either write qualifier is low.

Some behaviours can only be shown by the directed scenarios, because they depend on what the storage array holds:

- which words actually come out;
- that a masked location still holds its older word;
- that the first word after a read restart arrives with no extra latency;
- that a wrapped write overwrites location 0;
- that contents survive a long idle stretch.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  // Per-edge strobes from the control module to the datapath.
  typedef struct packed {
    logic wrStrobe;  // store wrData at the write address on this write edge
    logic rdStrobe;  // load the output register on this read edge
    logic rdBlank;   // load BLANK instead of the array word
  } sdmStrobe_t;

endpackage

// File: rtl/sdmAddrCounter.sv
module sdmAddrCounter #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          restart,
  input  logic          advance,
  output logic [AW-1:0] addrNow
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr;
  logic [AW-1:0] ptrNext;

  // A restart makes location 0 the location used on this very edge.
  assign addrNow = restart ? '0 : ptr;

  always_comb begin
    ptrNext = addrNow;
    if (advance) begin
      ptrNext = (addrNow == LAST) ? '0 : addrNow + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else       ptr <= ptrNext;
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !restart && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && !restart) |=> $stable(ptr));

  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !restart && ptr == LAST) |=> ptr == '0);

  assert_restart_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (restart && !advance) |=> ptr == '0);

  assert_restart_go_R3: assert property (@(posedge clk) disable iff (!rstN)
    (restart && advance && DEPTH > 1) |=> ptr == AW'(1));

endmodule

// File: rtl/sdmControl.sv
module sdmControl
  import sdm_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          rstN,
  input  logic          wrClk,
  input  logic          wrRestart,
  input  logic          wrEn,
  input  logic          inEn,
  input  logic          rdClk,
  input  logic          rdRestart,
  input  logic          rdEn,
  input  logic          outEn,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output sdmStrobe_t    strobes
);

  sdmAddrCounter #(.DEPTH(DEPTH)) wrCounter (
    .clk(wrClk), .rstN(rstN), .restart(wrRestart),
    .advance(wrEn), .addrNow(wrAddr)
  );

  sdmAddrCounter #(.DEPTH(DEPTH)) rdCounter (
    .clk(rdClk), .rstN(rstN), .restart(rdRestart),
    .advance(rdEn), .addrNow(rdAddr)
  );

  always_comb begin
    strobes.wrStrobe = wrEn & inEn;
    strobes.rdStrobe = rdEn;
    strobes.rdBlank  = ~outEn;
  end

  assert_masked_write_R5: assert property (@(posedge wrClk) disable iff (!rstN)
    strobes.wrStrobe |-> (wrEn && inEn));

endmodule

// File: rtl/sdmDatapath.sv
module sdmDatapath
  import sdm_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] BLANK = '0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             rstN,
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  sdmStrobe_t       strobes,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);

  // Storage array: written on the write clock, with no reset on its contents.
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobes.wrStrobe) store[wrAddr] <= wrData;
  end

  // Output register: loaded from the array on the read clock, or blanked.
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdData <= BLANK;
    end else if (strobes.rdStrobe) begin
      rdData <= strobes.rdBlank ? BLANK : store[rdAddr];
    end
  end

  assert_out_hold_R6: assert property (@(posedge rdClk) disable iff (!rstN)
    !strobes.rdStrobe |=> $stable(rdData));

  assert_out_blank_R7: assert property (@(posedge rdClk) disable iff (!rstN)
    (strobes.rdStrobe && strobes.rdBlank) |=> rdData == BLANK);

endmodule

// File: rtl/serialDelayMem.sv
module serialDelayMem
  import sdm_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] BLANK = '0
) (
  input  logic             rstN,
  input  logic             wrClk,
  input  logic             wrRestart,
  input  logic             wrEn,
  input  logic             inEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdClk,
  input  logic             rdRestart,
  input  logic             rdEn,
  input  logic             outEn,
  output logic [WIDTH-1:0] rdData
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;
  sdmStrobe_t    strobes;

  sdmControl #(.DEPTH(DEPTH)) ctrl (
    .rstN(rstN), .wrClk(wrClk), .wrRestart(wrRestart), .wrEn(wrEn), .inEn(inEn),
    .rdClk(rdClk), .rdRestart(rdRestart), .rdEn(rdEn), .outEn(outEn),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .strobes(strobes)
  );

  sdmDatapath #(.DEPTH(DEPTH), .WIDTH(WIDTH), .BLANK(BLANK)) dpath (
    .rstN(rstN), .wrClk(wrClk), .rdClk(rdClk), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .strobes(strobes), .wrData(wrData), .rdData(rdData)
  );

  assert_reset_blank_R1: assert property (@(posedge rdClk)
    !rstN |-> rdData == BLANK);

endmodule

// File: tb/tb_serialDelayMem.sv
module tb_serialDelayMem;

  localparam int DEPTH = 16;
  localparam int WIDTH = 8;
  localparam logic [7:0] BLANK = 8'h00;

  logic rstN = 1'b0;
  logic wrClk = 1'b0;
  logic rdClk = 1'b0;
  logic wrRestart = 1'b0, wrEn = 1'b0, inEn = 1'b0;
  logic [7:0] wrData = '0;
  logic rdRestart = 1'b0, rdEn = 1'b0, outEn = 1'b0;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;

  always #2.5 wrClk = ~wrClk;
  initial begin
    #1;
    forever #2.5 rdClk = ~rdClk;
  end

  serialDelayMem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .BLANK(BLANK)) dut (
    .rstN(rstN), .wrClk(wrClk), .wrRestart(wrRestart), .wrEn(wrEn), .inEn(inEn),
    .wrData(wrData), .rdClk(rdClk), .rdRestart(rdRestart), .rdEn(rdEn),
    .outEn(outEn), .rdData(rdData)
  );

  task automatic checkEq(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rdData=%h expected %h", req, act, exp);
    end
  endtask

  task automatic wrOp(logic rs, logic en, logic ie, logic [7:0] d);
    @(negedge wrClk);
    wrRestart = rs; wrEn = en; inEn = ie; wrData = d;
    @(posedge wrClk);
    #1;
    wrRestart = 1'b0; wrEn = 1'b0; inEn = 1'b0;
  endtask

  task automatic rdOp(logic rs, logic en, logic oe, logic [7:0] exp, string req);
    @(negedge rdClk);
    rdRestart = rs; rdEn = en; outEn = oe;
    @(posedge rdClk);
    #1;
    rdRestart = 1'b0; rdEn = 1'b0; outEn = 1'b0;
    checkEq(req, rdData, exp);
  endtask

  task automatic testReset;
    #1;
    checkEq("R1 reset", rdData, BLANK);
    repeat (3) @(posedge wrClk);
    rstN = 1'b1;
  endtask

  task automatic testStream;
    for (int i = 0; i < 8; i++) wrOp(i == 0, 1'b1, 1'b1, 8'h10 + 8'(i));
    for (int i = 0; i < 8; i++) rdOp(i == 0, 1'b1, 1'b1, 8'h10 + 8'(i), i == 0 ? "R3 first word" : "R2 stream");
  endtask

  task automatic testWriteEnable;
    wrOp(1'b1, 1'b0, 1'b1, 8'hEE);  // R9: restart with wrEn low
    wrOp(1'b0, 1'b1, 1'b1, 8'hA0);  // lands at location 0
    wrOp(1'b0, 1'b0, 1'b1, 8'hFF);  // R4: frozen, nothing stored
    wrOp(1'b0, 1'b1, 1'b1, 8'hA1);  // location 1
    rdOp(1'b1, 1'b1, 1'b1, 8'hA0, "R9 restart priority");
    rdOp(1'b0, 1'b1, 1'b1, 8'hA1, "R4 write enable low");
  endtask

  task automatic testInputEnable;
    wrOp(1'b1, 1'b1, 1'b1, 8'hB0);
    wrOp(1'b0, 1'b1, 1'b0, 8'hCC);  // R5: masked, address steps
    wrOp(1'b0, 1'b1, 1'b1, 8'hB2);
    rdOp(1'b1, 1'b1, 1'b1, 8'hB0, "R5 loc0");
    rdOp(1'b0, 1'b1, 1'b1, 8'hA1, "R5 masked loc keeps old");
    rdOp(1'b0, 1'b1, 1'b1, 8'hB2, "R5 addr advanced");
  endtask

  task automatic testReadEnable;
    rdOp(1'b1, 1'b1, 1'b1, 8'hB0, "R3 restart");
    rdOp(1'b0, 1'b0, 1'b1, 8'hB0, "R6 output held");
    rdOp(1'b0, 1'b0, 1'b1, 8'hB0, "R6 output held again");
    rdOp(1'b0, 1'b1, 1'b1, 8'hA1, "R6 address held");
    rdOp(1'b1, 1'b0, 1'b1, 8'hA1, "R9 read restart, en low");
    rdOp(1'b0, 1'b1, 1'b1, 8'hB0, "R9 read restart to 0");
  endtask

  task automatic testOutputEnable;
    rdOp(1'b1, 1'b1, 1'b0, BLANK, "R7 blanked");
    rdOp(1'b0, 1'b1, 1'b1, 8'hA1, "R7 address advanced");
    rdOp(1'b0, 1'b1, 1'b0, BLANK, "R7 blanked mid");
    rdOp(1'b0, 1'b1, 1'b1, 8'h13, "R7 skip to loc3");
  endtask

  task automatic testWrap;
    for (int i = 0; i < DEPTH; i++) wrOp(i == 0, 1'b1, 1'b1, 8'h40 + 8'(i));
    wrOp(1'b0, 1'b1, 1'b1, 8'h77);  // wraps to location 0
    rdOp(1'b1, 1'b1, 1'b1, 8'h77, "R8 write wrap");
    for (int i = 1; i < DEPTH; i++) rdOp(1'b0, 1'b1, 1'b1, 8'h40 + 8'(i), "R8 walk");
    rdOp(1'b0, 1'b1, 1'b1, 8'h77, "R8 read wrap");
  endtask

  task automatic testRetention;
    wrOp(1'b1, 1'b1, 1'b1, 8'h5A);
    wrOp(1'b0, 1'b1, 1'b1, 8'hA5);
    repeat (2000) @(posedge wrClk);
    rdOp(1'b1, 1'b1, 1'b1, 8'h5A, "R10 retention loc0");
    rdOp(1'b0, 1'b1, 1'b1, 8'hA5, "R10 retention loc1");
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testStream();
    testWriteEnable();
    testInputEnable();
    testReadEnable();
    testOutputEnable();
    testWrap();
    testRetention();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule